// File: doc/BRIEF.md
# Gated Modulo Pulse Counter with Halt Capture

This block tallies single-cycle event pulses during a counting window that lasts while `enable` is held high. The running tally cycles through the values 0 to 5 and returns to 0 on the event after 5, so after any number of events it holds that number reduced modulo 6. Dropping `enable` at any point clears the tally, and the next rise of `enable` opens a fresh window.

A `halt` pulse closes the window. The value the tally reaches on that edge, including an event that arrives together with `halt`, is copied into `result_o`, and `done_o` rises. From then on the tally, the result and the flag stay frozen until `enable` falls. The captured result stays readable after `enable` falls and is replaced only by the next halt.

The wrap point and the counter width are parameters. A generate branch selects a plain binary increment when the wrap point is the all-ones value of the width, and a compare-and-clear step otherwise.

Top module: `pulse_window_counter`

## Requirements
- R1: While `rst_n` is low, `count_o`, `result_o` and `done_o` are all 0 after the next clock edge.
- R2: With `enable` high and `done_o` low, a cycle in which `tick` is high and `count_o` is below 5 makes `count_o` one larger after that clock edge.
- R3: With `enable` high and `done_o` low, a cycle in which `tick` is low leaves `count_o` unchanged.
- R4: A `tick` while `count_o` equals 5 (and `enable` high, `done_o` low) makes `count_o` 0 after the edge. `count_o` never exceeds 5.
- R5: A cycle with `enable` low makes `count_o` 0 and `done_o` 0 after the edge, whatever `tick` and `halt` do. Events while `enable` is low are not counted.
- R6: With `enable` high and `done_o` low, a cycle with `halt` high sets `done_o` after that edge. At the same edge `result_o` takes the value `count_o` reaches, which includes a `tick` in the same cycle as `halt`.
- R7: While `done_o` is high and `enable` stays high, further `tick` and `halt` pulses change neither `count_o`, `result_o` nor `done_o`.
- R8: After `enable` falls and rises again, the window restarts with `count_o` at 0 and `done_o` at 0. `result_o` keeps the last captured value until the next halt.
- R9: In the cycle after a halt, `result_o` equals the number of `tick` cycles in the window, counting the one coincident with `halt`, modulo 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Window gate; low clears the tally and the done flag |
| tick | input | 1 | Event pulse, one count per high cycle |
| halt | input | 1 | Closes the window and captures the tally |
| count_o | output | CNT_W (3) | Running tally, 0 to 5 |
| result_o | output | CNT_W (3) | Tally captured at the last halt |
| done_o | output | 1 | High from the cycle after a halt until `enable` falls |

## Verification
Every result is one register stage deep. The tally, the captured result and the done flag all reflect the inputs of a cycle right after the rising edge that consumes them. The bench therefore applies one input vector per cycle and samples shortly after the following edge, before it drives the next vector. At each halt the driver pushes the modulo-6 event count it has kept for that window into a queue. A monitor pops that value on the cycle `done_o` first reads high, which is exactly one edge after the halt, and compares it with `result_o`. At the end the queue must be empty, so no captured result is missing or extra.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   // Window state: counting events, or holding a captured result.
   typedef enum logic {
      WIN_OPEN = 1'b0,
      WIN_HELD = 1'b1
   } win_state_t;

endpackage : pwc_pkg

// File: rtl/pwc_step.sv
// Combinational next-tally step with wrap. The variant is chosen by parameters.
module pwc_step #(
   parameter int CNT_W    = 3,
   parameter int WRAP_MAX = 5
) (
   input  logic [CNT_W-1:0] cur,
   input  logic             adv,
   output logic [CNT_W-1:0] nxt
);

   localparam logic [CNT_W-1:0] LAST     = CNT_W'(WRAP_MAX);
   localparam bit               FULL_POW = (WRAP_MAX == (1 << CNT_W) - 1);

   generate
      if (FULL_POW) begin : g_natural
         // The wrap point is all ones, so binary overflow wraps by itself.
         always_comb begin
            nxt = adv ? cur + 1'b1 : cur;
         end
      end else begin : g_compare
         always_comb begin
            if (!adv) begin
               nxt = cur;
            end else if (cur == LAST) begin
               nxt = '0;
            end else begin
               nxt = cur + 1'b1;
            end
         end
      end
   endgenerate

endmodule : pwc_step

// File: rtl/pwc_count_reg.sv
// Running tally register: clear has priority, hold freezes it.
module pwc_count_reg #(
   parameter int CNT_W    = 3,
   parameter int WRAP_MAX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             hold,
   input  logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (!hold) begin
         count <= nxt;
      end
   end

   // R5: a dropped enable empties the tally on the next edge
   assert_clear_empties_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   // R4: the tally never leaves the range 0..WRAP_MAX
   assert_in_range_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= LAST);

   // R7: a held tally keeps its value
   assert_hold_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clear) |=> $stable(count));

endmodule : pwc_count_reg

// File: rtl/pwc_window_ctl.sv
// Window control: decides when to capture and drives the done flag.
module pwc_window_ctl
   import pwc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic halt,
   output logic capture,
   output logic done
);

   win_state_t state;

   always_comb begin
      capture = enable && (state == WIN_OPEN) && halt;
      done    = (state == WIN_HELD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= WIN_OPEN;
      end else if (!enable) begin
         state <= WIN_OPEN;
      end else if (capture) begin
         state <= WIN_HELD;
      end
   end

   // R7: once held, the window stays held while enable stays high
   assert_held_sticks_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && enable) |=> done);

   // R5: a low enable reopens the window
   assert_enable_low_reopens_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !done);

endmodule : pwc_window_ctl

// File: rtl/pwc_capture.sv
// Result register: loads only on a capture strobe.
module pwc_capture #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CNT_W-1:0] d,
   output logic [CNT_W-1:0] result
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
      end else if (capture) begin
         result <= d;
      end
   end

   // R7 / R8: the result moves only at a capture
   assert_result_frozen_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(result));

endmodule : pwc_capture

// File: rtl/pulse_window_counter.sv
module pulse_window_counter #(
   parameter int CNT_W    = 3,
   parameter int WRAP_MAX = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic             halt,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] result_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP_MAX);

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("pulse_window_counter: CNT_W must be at least 1");
      end
      if (WRAP_MAX < 1 || WRAP_MAX >= (1 << CNT_W)) begin : g_bad_wrap
         $error("pulse_window_counter: WRAP_MAX must lie in 1 .. 2**CNT_W-1");
      end
   endgenerate

   logic [CNT_W-1:0] next_cnt;
   logic             capture;

   pwc_step #(
      .CNT_W    (CNT_W),
      .WRAP_MAX (WRAP_MAX)
   ) i_step (
      .cur (count_o),
      .adv (tick),
      .nxt (next_cnt)
   );

   pwc_window_ctl i_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .halt    (halt),
      .capture (capture),
      .done    (done_o)
   );

   pwc_count_reg #(
      .CNT_W    (CNT_W),
      .WRAP_MAX (WRAP_MAX)
   ) i_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!enable),
      .hold  (done_o),
      .nxt   (next_cnt),
      .count (count_o)
   );

   pwc_capture #(
      .CNT_W (CNT_W)
   ) i_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .d       (next_cnt),
      .result  (result_o)
   );

   // R2: an event below the wrap point adds one
   assert_step_up_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !done_o && tick && count_o != LAST)
      |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

   // R3: a quiet cycle keeps the tally
   assert_quiet_keeps_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !done_o && !tick) |=> $stable(count_o));

   // R4: an event at the wrap point returns to zero
   assert_wrap_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !done_o && tick && count_o == LAST) |=> (count_o == '0));

   // R6: a halt raises done and the result matches the tally it froze
   assert_halt_capture_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !done_o && halt) |=> (done_o && result_o == count_o));

endmodule : pulse_window_counter

// File: tb/test_pulse_window_counter.sv
`timescale 1ns/1ps
module test_pulse_window_counter;

   localparam int CNT_W = 3;
   localparam int MODV  = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic             tick = 1'b0;
   logic             halt = 1'b0;
   logic [CNT_W-1:0] count_o;
   logic [CNT_W-1:0] result_o;
   logic             done_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;
   int exp_q[$];

   always #2 clk = ~clk;   // 250 MHz

   pulse_window_counter #(.CNT_W(CNT_W), .WRAP_MAX(5)) i_pulse_window_counter (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .halt(halt),
      .count_o(count_o), .result_o(result_o), .done_o(done_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One cycle: apply inputs, pass the edge, land 1 ns after it.
   task automatic cyc(input logic en, input logic ev, input logic h);
      enable = en; tick = ev; halt = h;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // Scoreboard monitor: the result is due on the first cycle done reads high.
   initial begin : monitor
      logic prev_done;
      prev_done = 1'b0;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && done_o && !prev_done) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected capture", 1, 0);
            end else begin
               check("R9 scoreboard result", int'(result_o), exp_q.pop_front());
            end
         end
         prev_done = done_o;
      end
   end

   initial begin : watchdog
      #(4 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : driver
      int ref_cnt;
      int total;
      // R1: reset state
      rst_n = 1'b0;
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 1'b1);
      check("R1 count after reset", int'(count_o), 0);
      check("R1 result after reset", int'(result_o), 0);
      check("R1 done after reset", int'(done_o), 0);
      rst_n = 1'b1;

      // R5: events with enable low are not counted
      cyc(1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 1'b1);
      check("R5 count with enable low", int'(count_o), 0);
      check("R5 done with enable low", int'(done_o), 0);

      // R2: counting up
      for (int i = 1; i <= 3; i++) begin
         cyc(1'b1, 1'b1, 1'b0);
         check("R2 step up", int'(count_o), i);
      end
      // R3: quiet cycles hold
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      check("R3 quiet hold", int'(count_o), 3);
      // R4: reach 5 and wrap to 0
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      check("R4 reach five", int'(count_o), 5);
      cyc(1'b1, 1'b1, 1'b0);
      check("R4 wrap to zero", int'(count_o), 0);

      // R6: event together with halt is counted (7 events so far -> 1)
      exp_q.push_back(7 % MODV);
      cyc(1'b1, 1'b1, 1'b1);
      check("R6 done after halt", int'(done_o), 1);
      check("R6 coincident event captured", int'(result_o), 1);
      check("R6 count at halt", int'(count_o), 1);

      // R7: events and halts while done are ignored
      cyc(1'b1, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b1);
      check("R7 count frozen", int'(count_o), 1);
      check("R7 result frozen", int'(result_o), 1);
      check("R7 done held", int'(done_o), 1);

      // R5 / R8: enable drop clears count and done, result kept
      cyc(1'b0, 1'b1, 1'b0);
      check("R5 count cleared on drop", int'(count_o), 0);
      check("R5 done cleared on drop", int'(done_o), 0);
      check("R8 result kept after drop", int'(result_o), 1);

      // R8: drop mid-window discards the partial tally
      cyc(1'b1, 1'b1, 1'b0);
      cyc(1'b1, 1'b1, 1'b0);
      check("R2 partial window", int'(count_o), 2);
      cyc(1'b0, 1'b0, 1'b0);
      check("R8 partial cleared", int'(count_o), 0);
      cyc(1'b1, 1'b1, 1'b0);
      check("R8 fresh window count", int'(count_o), 1);
      check("R8 result kept in new window", int'(result_o), 1);
      exp_q.push_back(1 % MODV);
      cyc(1'b1, 1'b0, 1'b1);
      check("R6 halt without event", int'(result_o), 1);
      cyc(1'b0, 1'b0, 1'b0);

      // R9: random windows of up to 100 events, scoreboard checks results
      for (int w = 0; w < 24; w++) begin
         int n_ev;
         int gap;
         logic last_ev;
         n_ev = int'($urandom_range(0, 100));
         total = 0;
         ref_cnt = 0;
         for (int e = 0; e < n_ev; e++) begin
            gap = int'($urandom_range(0, 2));
            for (int g = 0; g < gap; g++) begin
               cyc(1'b1, 1'b0, 1'b0);
            end
            cyc(1'b1, 1'b1, 1'b0);
            total++;
            ref_cnt = (ref_cnt == 5) ? 0 : ref_cnt + 1;
         end
         check("R9 running tally", int'(count_o), ref_cnt);
         last_ev = logic'($urandom_range(0, 1));
         if (last_ev) total++;
         exp_q.push_back(total % MODV);
         cyc(1'b1, last_ev, 1'b1);
         cyc(1'b1, 1'b1, 1'b0);
         check("R7 result held in random window", int'(result_o), total % MODV);
         cyc(1'b0, 1'b0, 1'b0);
      end

      cyc(1'b0, 1'b0, 1'b0);
      check("R9 all results consumed", exp_q.size(), 0);
      finish_run();
   end

endmodule : test_pulse_window_counter